// File: doc/BRIEF.md
# Receive Line FIFO with Status and Interrupt Logic

This block sits behind a serial receiver. Incoming bytes go into a small FIFO organised as 4-byte lines, and software or a DMA engine reads it back one 32-bit line at a time. From the fill level the block derives a data-ready flag, a half-full flag and a near-full flag. A buffer-closed event raises a flag that hides data-ready and blocks reads until it is acknowledged. In DMA mode the hardware acknowledges that flag itself.

Two asynchronous modem inputs, carrier detect and ring indicator, are synchronised. Each gets a sticky change flag. The enabled flags are merged into one interrupt line. Acknowledges use a write strobe with a clear mask, where a 1 clears a flag.

Top module: `rx_status_ctl`

## Requirements
- R1: After reset, every bit of `status` is 0 and `irq` is 0.
- R2: Bytes are packed into 32-bit lines, with the earliest byte in bits 7:0 of `rd_word`. `rd_word` shows the oldest complete line. A `rd_en` cycle removes that line. `status[0]` (data ready) is 1 when at least one whole line is held and buffer-closed is 0.
- R3: A byte written while the FIFO already holds 32 bytes is dropped, and the stored contents do not change.
- R4: `status[1]` (half full) is 1 exactly when the FIFO holds 20 or more bytes.
- R5: `status[2]` (near full) is 1 exactly when the FIFO holds 28 or more bytes, which leaves room for one more line.
- R6: A `close_evt` pulse sets `status[3]` (buffer closed). While it is set, `status[0]` reads 0 and `rd_en` removes nothing.
- R7: With `ack_we` high, `ack_clr[0]`=1 clears buffer-closed and `ack_clr[0]`=0 leaves it unchanged. A `close_evt` in the same cycle wins over the clear.
- R8: With `dma_mode`=1, buffer-closed clears by itself one cycle after it sets, with no acknowledge write.
- R9: `dcd_in` passes through two synchroniser flops. Either edge then sets `status[4]` one cycle later, but only while `ie_dcd`=1. A set takes 3 clock edges from the input change. The flag is cleared by `ack_clr[1]`=1 under `ack_we`, and a set in the same cycle wins.
- R10: `ri_in` works the same way as in R9. It uses `ie_ri`, `status[5]` and `ack_clr[2]`.
- R11: `irq` is the OR of half full AND `ie_half`, buffer closed AND `ie_bc`, `status[4]` AND `ie_dcd`, and `status[5]` AND `ie_ri`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe from the receiver |
| wr_byte | input | 8 | Received byte |
| rd_en | input | 1 | Pops one line |
| rd_word | output | 32 | Oldest complete line |
| close_evt | input | 1 | Buffer-closed event |
| dma_mode | input | 1 | Hardware acknowledges buffer-closed |
| ie_half | input | 1 | Half-full interrupt enable |
| ie_bc | input | 1 | Buffer-closed interrupt enable |
| ie_dcd | input | 1 | Carrier-detect change enable |
| ie_ri | input | 1 | Ring-indicator change enable |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_clr | input | 3 | Clear mask: bit0 buffer closed, bit1 DCD change, bit2 RI change |
| dcd_in | input | 1 | Asynchronous carrier detect |
| ri_in | input | 1 | Asynchronous ring indicator |
| status | output | 6 | {ri_chg, dcd_chg, closed, near_full, half, ready} |
| irq | output | 1 | Combined interrupt |

## Verification
The FIFO is swept through every fill level from 0 to 32 bytes and back to 0. The bytes follow an arithmetic pattern, so the flag thresholds at 4, 20 and 28 bytes can each be seen turning on and off. The same pattern also shows whether the byte order within a line is correct. An extra write into a full FIFO separates dropping the byte from overwriting data. The buffer-closed sequence checks a read while closed, an acknowledge with a zero mask, an acknowledge in the same cycle as a close, and DMA auto-clear. Modem edges with the enable off and on, sampled at two and at three clock edges, separate the gating from the synchroniser latency. All 16 enable combinations are then applied with every source active, and again with only some sources active.

// File: rtl/rx_status_ctl.sv
module rx_status_ctl #(
  parameter int LINE_BYTES  = 4,
  parameter int DEPTH_LINES = 8,
  parameter int HALF_LINES  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              wr_byte,
  input  logic                    rd_en,
  output logic [8*LINE_BYTES-1:0] rd_word,
  input  logic                    close_evt,
  input  logic                    dma_mode,
  input  logic                    ie_half,
  input  logic                    ie_bc,
  input  logic                    ie_dcd,
  input  logic                    ie_ri,
  input  logic                    ack_we,
  input  logic [2:0]              ack_clr,
  input  logic                    dcd_in,
  input  logic                    ri_in,
  output logic [5:0]              status,
  output logic                    irq
);
  localparam int DEPTH_BYTES = LINE_BYTES * DEPTH_LINES;
  localparam int CW = $clog2(DEPTH_BYTES + 1);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int LW = $clog2(DEPTH_LINES);
  localparam int IW = $clog2(LINE_BYTES);
  localparam int HALF_LVL = HALF_LINES * LINE_BYTES;
  localparam int NEAR_LVL = (DEPTH_LINES - 1) * LINE_BYTES;

  logic [7:0]    mem [DEPTH_BYTES];
  logic [AW-1:0] wptr;
  logic [LW-1:0] rptr;
  logic [CW-1:0] count;
  logic          bc, dcd_chg, ri_chg;
  logic [2:0]    dcd_s, ri_s;

  wire wr_ok    = wr_en && (count < CW'(DEPTH_BYTES));
  wire has_line = count >= CW'(LINE_BYTES);
  wire rd_ok    = rd_en && has_line && !bc;
  wire half     = count >= CW'(HALF_LVL);
  wire near     = count >= CW'(NEAR_LVL);
  wire dcd_edge = dcd_s[2] ^ dcd_s[1];
  wire ri_edge  = ri_s[2] ^ ri_s[1];

  for (genvar i = 0; i < LINE_BYTES; i++) begin : g_word
    assign rd_word[8*i +: 8] = mem[{rptr, IW'(i)}];
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      bc      <= 1'b0;
      dcd_chg <= 1'b0;
      ri_chg  <= 1'b0;
      dcd_s   <= '0;
      ri_s    <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      count   <= count + CW'(wr_ok) - (rd_ok ? CW'(LINE_BYTES) : CW'(0));
      bc      <= close_evt | (bc & ~dma_mode & ~(ack_we & ack_clr[0]));
      dcd_s   <= {dcd_s[1:0], dcd_in};
      ri_s    <= {ri_s[1:0], ri_in};
      dcd_chg <= (ie_dcd & dcd_edge) | (dcd_chg & ~(ack_we & ack_clr[1]));
      ri_chg  <= (ie_ri & ri_edge) | (ri_chg & ~(ack_we & ack_clr[2]));
    end
  end

  assign status = {ri_chg, dcd_chg, bc, near, half, has_line & ~bc};
  assign irq    = (ie_half & half) | (ie_bc & bc) | (ie_dcd & dcd_chg) | (ie_ri & ri_chg);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH_BYTES));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH_BYTES) && wr_en && !rd_ok) |=> $stable(wptr));
  p_rd_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bc && rd_en) |=> $stable(rptr));
  p_keep_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc && !dma_mode && !(ack_we && ack_clr[0])) |=> bc);
  p_dma_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && bc && !close_evt) |=> !bc);
  p_dcd_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_dcd && !dcd_chg) |=> !dcd_chg);
  p_ri_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_ri && !ri_chg) |=> !ri_chg);
endmodule

// File: tb/test_rx_status_ctl.sv
module test_rx_status_ctl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, close_evt = 0, dma_mode = 0;
  logic ie_half = 0, ie_bc = 0, ie_dcd = 0, ie_ri = 0, ack_we = 0;
  logic [7:0] wr_byte = 0;
  logic [2:0] ack_clr = 0;
  logic dcd_in = 0, ri_in = 0;
  logic [31:0] rd_word;
  logic [5:0] status;
  logic irq;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_status_ctl i_rx_status_ctl (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int k);
    return 8'((k * 7 + 3) & 8'hff);
  endfunction

  task automatic push(logic [7:0] b);
    wr_en = 1; wr_byte = b; @(negedge clk); wr_en = 0;
  endtask
  task automatic pop();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask
  task automatic ack(logic [2:0] m, logic cl);
    ack_we = 1; ack_clr = m; close_evt = cl; @(negedge clk);
    ack_we = 0; ack_clr = 0; close_evt = 0;
  endtask
  task automatic lvl_chk(int n);
    chk("R2 ready", status[0], n >= 4);
    chk("R4 half", status[1], n >= 20);
    chk("R5 near", status[2], n >= 28);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; vecs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);

    // R2 R4 R5: fill sweep
    for (int n = 1; n <= 32; n++) begin push(pat(n - 1)); lvl_chk(n); end
    push(8'hEE);                                   // R3
    lvl_chk(32);
    for (int l = 0; l < 8; l++) begin
      chk("R2 R3 word", rd_word, {pat(4*l+3), pat(4*l+2), pat(4*l+1), pat(4*l)});
      pop();
      lvl_chk(32 - 4 * (l + 1));
    end

    // R6 R7 interlock
    for (int k = 0; k < 8; k++) push(8'(8'h10 + (k / 4) * 16 + k % 4));
    ie_bc = 1;
    ack(3'b000, 1);
    chk("R6 closed", status[3], 1);
    chk("R6 ready masked", status[0], 0);
    chk("R11 irq bc", irq, 1);
    pop();
    ack(3'b000, 0);
    chk("R7 zero mask keeps", status[3], 1);
    ack(3'b001, 1);
    chk("R7 set wins", status[3], 1);
    ack(3'b001, 0);
    chk("R7 cleared", status[3], 0);
    chk("R7 ready back", status[0], 1);
    chk("R11 irq off", irq, 0);
    chk("R6 read ignored", rd_word, 32'h13121110);
    pop();
    chk("R2 next line", rd_word, 32'h23222120);
    pop();
    chk("R2 empty", status[0], 0);

    // R8 DMA auto clear
    dma_mode = 1;
    close_evt = 1; @(negedge clk); close_evt = 0;
    chk("R8 set", status[3], 1);
    @(negedge clk);
    chk("R8 auto clear", status[3], 0);
    dma_mode = 0; ie_bc = 0;

    // R9 R10 modem change
    dcd_in = 1; ri_in = 1;
    repeat (4) @(negedge clk);
    chk("R9 gated", status[4], 0);
    chk("R10 gated", status[5], 0);
    ie_dcd = 1; ie_ri = 1;
    dcd_in = 0; ri_in = 0;
    repeat (2) @(negedge clk);
    chk("R9 latency", status[4], 0);
    chk("R10 latency", status[5], 0);
    @(negedge clk);
    chk("R9 fall set", status[4], 1);
    chk("R10 fall set", status[5], 1);
    ack(3'b000, 0);
    chk("R9 zero keeps", status[4], 1);
    ack(3'b010, 0);
    chk("R9 cleared", status[4], 0);
    chk("R10 untouched", status[5], 1);
    ack(3'b100, 0);
    chk("R10 cleared", status[5], 0);
    dcd_in = 1;
    repeat (3) @(negedge clk);
    chk("R9 rise set", status[4], 1);

    // R11 enable sweep
    for (int k = 0; k < 20; k++) push(8'(k));
    ie_bc = 1; ack(3'b000, 1);
    ri_in = 1; repeat (4) @(negedge clk);
    for (int m = 0; m < 16; m++) begin
      {ie_ri, ie_dcd, ie_bc, ie_half} = 4'(m); #1;
      chk("R11 all active", irq, m != 0);
      @(negedge clk);
    end
    ack(3'b110, 0);
    for (int m = 0; m < 16; m++) begin
      {ie_ri, ie_dcd, ie_bc, ie_half} = 4'(m); #1;
      chk("R11 partial", irq, (m & 3) != 0);
      @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule